// File: doc/BRIEF.md
# Multiprocessor Interrupt Router with Interval Timers

This block collects level-sensitive interrupt requests from up to 64 device lines and routes them to up to four processors. Every processor has its own 64-bit enable mask, and its hard interrupt output is high whenever that mask shares a set bit with the captured request vector. One request position is taken from the output of a cascaded legacy interrupt controller rather than from its device line. A read-only view gives each processor its masked request vector, and another read-only offset returns the raw request vector.

A control word drives the other interrupt classes. Processors signal each other through inter-processor interrupt bits that are set by a shifted field and cleared by writing ones. Timer acknowledge bits are also cleared by writing ones. A small arbitration field takes a value only while it is empty, so software can use it as a lock. Four interval counters, one per processor, count down on each asserting edge of an external periodic tick. When a counter runs below zero it sets a sticky flag, and from then on each tick raises that processor's timer interrupt.

Software reaches all state through a single-cycle 64-bit register port. Reads are combinational from the current state, and writes take effect at the next clock edge.

Top module: `irq_router_top`

## Requirements
- R1: Request bit n holds the level of device line n, captured one clock after it changes. Bit 55 holds the legacy controller input, and device line 55 has no effect. Reading offset 0x300 returns the request vector.
- R2: The processor masks for processors 0, 1, 2 and 3 are read/write 64-bit registers at offsets 0x200, 0x240, 0x600 and 0x640. They reset to zero.
- R3: hard_irq_o[i] is high exactly when mask i AND the request vector is non-zero. It follows a mask write at that write's clock edge and a line change one clock after the change.
- R4: Offsets 0x280, 0x2C0, 0x680 and 0x6C0 return masks 0 to 3 ANDed with the request vector. Writes to these offsets and to 0x300 change no state.
- R5: A valid access to any other offset sets bus_err_o and returns all-ones read data. A decoded offset returns bus_err_o low.
- R6: The control word sits at offset 0x080 and resets to 0x8_0000_0000. A read returns the stored value ORed with the 2-bit processor id on bus_cpu_i.
- R7: A control-word write makes these changes. Each written one inside mask 0x1000_0FF0 clears that stored bit. Written bits 15:12 are ORed into stored bits 11:8. Stored bits 43:40 take the written bits 43:40.
- R8: On a control-word write with written bit 20 set, stored bits 23:16 are cleared. When written bit 20 is clear, written bits 23:20 are ORed in, and written bits 19:16 are loaded only if stored bits 19:16 are all zero.
- R9: ipi_o[i] equals stored control bit 8+i.
- R10: The interval counters of processors 0 to 3 sit at offsets 0x380, 0x3C0, 0x700 and 0x740. A write loads written bits 23:0 and clears sticky bit 24. A read returns the 25-bit value.
- R11: Each rising edge of tick_i decrements every counter once, no matter how long the level is held. The decrement is done as 25 bits, and bit 24 stays set once it is set. A counter write in the same cycle wins over the tick.
- R12: When bit 24 of counter i is set after a tick, control bit 4+i and timer_irq_o[i] are set at that same clock edge.
- R13: A control-word write that leaves stored bit 4+i at zero drops timer_irq_o[i]. A timer interrupt stays high until such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_lines_i | input | NUM_LINES | Level device request lines |
| legacy_pic_i | input | 1 | Cascaded legacy controller output |
| tick_i | input | 1 | Periodic timer tick |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Register byte offset |
| bus_cpu_i | input | 2 | Id of the accessing processor |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data (combinational) |
| bus_err_o | output | 1 | Undecoded offset flag |
| hard_irq_o | output | NUM_CPU | Device interrupt per processor |
| ipi_o | output | NUM_CPU | Inter-processor interrupt per processor |
| timer_irq_o | output | NUM_CPU | Timer interrupt per processor |

## Verification
Routing is tested with requests on an ordinary line, on the legacy input, and on the device line that the legacy input hides. This shows whether the request vector takes its bits from the right sources and whether each mask selects only its own processor. The control word gets separate write patterns for set-by-field, write-one-to-clear, replace, arbitration load when empty, arbitration hold when full, and arbitration clear, so a mix-up between these write semantics shows up as a wrong read value. The counters are ticked with a held level to confirm one decrement per edge, and are driven through zero, wrap and sticky decrement to separate an underflow from a counter that just reaches zero.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int DATA_W = 64;
   localparam int ADDR_W = 12;

   // fixed offsets
   localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h080;
   localparam logic [ADDR_W-1:0] OFF_RAW  = 12'h300;

   // control word layout (software decodes these positions)
   localparam int TACK_LSB    = 4;
   localparam int IPI_LSB     = 8;
   localparam int IPI_SET_LSB = 12;
   localparam int ARB_LO_LSB  = 16;
   localparam int ARB_HI_LSB  = 20;
   localparam int ARB_CLR_BIT = 20;
   localparam int SPARE_LSB   = 40;
   localparam logic [DATA_W-1:0] CTRL_W1C_MASK = 64'h0000_0000_1000_0FF0;
   localparam logic [DATA_W-1:0] CTRL_RESET    = 64'h0000_0008_0000_0000;

   function automatic logic [ADDR_W-1:0] mask_off(input int i);
      return (i < 2) ? ADDR_W'(12'h200 + i * 64) : ADDR_W'(12'h600 + (i - 2) * 64);
   endfunction

   function automatic logic [ADDR_W-1:0] view_off(input int i);
      return mask_off(i) + ADDR_W'(12'h080);
   endfunction

   function automatic logic [ADDR_W-1:0] cnt_off(input int i);
      return (i < 2) ? ADDR_W'(12'h380 + i * 64) : ADDR_W'(12'h700 + (i - 2) * 64);
   endfunction

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
   parameter int NUM_LINES   = 64,
   parameter int LEGACY_LINE = 55
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   input  logic                 legacy_i,
   output logic [NUM_LINES-1:0] req_o
);

   logic [NUM_LINES-1:0] merged;

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_bit
      if (n == LEGACY_LINE) begin : g_legacy
         assign merged[n] = legacy_i;
      end else begin : g_line
         assign merged[n] = lines_i[n];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_o <= '0;
      else        req_o <= merged;
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NUM_CPU   = 4,
   parameter int NUM_LINES = 64
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_CPU-1:0]                 wr_en_i,
   input  logic [NUM_LINES-1:0]               wdata_i,
   input  logic [NUM_LINES-1:0]               req_i,
   output logic [NUM_CPU-1:0][NUM_LINES-1:0]  mask_o,
   output logic [NUM_CPU-1:0]                 hard_irq_o
);

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
      always_ff @(posedge clk) begin
         if (!rst_n)          mask_o[g] <= '0;
         else if (wr_en_i[g]) mask_o[g] <= wdata_i;
      end
      assign hard_irq_o[g] = |(mask_o[g] & req_i);
   end

endmodule

// File: rtl/irq_ctrl_word.sv
module irq_ctrl_word
   import irq_router_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_CPU-1:0] fire_i,
   output logic [DATA_W-1:0]  ctrl_o,
   output logic [NUM_CPU-1:0] ipi_o,
   output logic [NUM_CPU-1:0] timer_irq_o
);

   logic [DATA_W-1:0]  after_wr;
   logic [DATA_W-1:0]  ctrl_nxt;
   logic [NUM_CPU-1:0] tmr_nxt;

   always_comb begin
      after_wr = ctrl_o;
      if (wr_i) begin
         after_wr = after_wr & ~(wdata_i & CTRL_W1C_MASK);
         if (wdata_i[ARB_CLR_BIT]) begin
            after_wr[ARB_LO_LSB +: 8] = '0;
         end else begin
            after_wr[ARB_HI_LSB +: 4] = after_wr[ARB_HI_LSB +: 4] | wdata_i[ARB_HI_LSB +: 4];
            if (after_wr[ARB_LO_LSB +: 4] == 4'h0)
               after_wr[ARB_LO_LSB +: 4] = wdata_i[ARB_LO_LSB +: 4];
         end
         after_wr[IPI_LSB +: 4] = after_wr[IPI_LSB +: 4] | wdata_i[IPI_SET_LSB +: 4];
         after_wr[SPARE_LSB +: 4] = wdata_i[SPARE_LSB +: 4];
      end
      ctrl_nxt = after_wr;
      tmr_nxt  = timer_irq_o;
      for (int i = 0; i < NUM_CPU; i++) begin
         if (wr_i && !after_wr[TACK_LSB + i]) tmr_nxt[i] = 1'b0;
         if (fire_i[i]) begin
            ctrl_nxt[TACK_LSB + i] = 1'b1;
            tmr_nxt[i]             = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_o      <= CTRL_RESET;
         timer_irq_o <= '0;
      end else begin
         ctrl_o      <= ctrl_nxt;
         timer_irq_o <= tmr_nxt;
      end
   end

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_ipi
      assign ipi_o[g] = ctrl_o[IPI_LSB + g];
   end

endmodule

// File: rtl/irq_interval_bank.sv
module irq_interval_bank #(
   parameter int NUM_CPU     = 4,
   parameter int CNT_W       = 24,
   parameter bit TICK_RISING = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick_i,
   input  logic [NUM_CPU-1:0]             wr_en_i,
   input  logic [CNT_W-1:0]               wdata_i,
   output logic [NUM_CPU-1:0][CNT_W:0]    cnt_o,
   output logic [NUM_CPU-1:0]             fire_o
);

   logic tick_q;
   logic step;

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= ~TICK_RISING;
      else        tick_q <= tick_i;
   end

   if (TICK_RISING) begin : g_rise
      assign step = tick_i & ~tick_q;
   end else begin : g_fall
      assign step = ~tick_i & tick_q;
   end

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_cnt
      logic [CNT_W:0] dec;
      logic [CNT_W:0] stepped;

      assign dec     = cnt_o[g] - (CNT_W+1)'(1);
      assign stepped = {cnt_o[g][CNT_W] | dec[CNT_W], dec[CNT_W-1:0]};

      always_ff @(posedge clk) begin
         if (!rst_n)          cnt_o[g] <= '0;
         else if (wr_en_i[g]) cnt_o[g] <= {1'b0, wdata_i};
         else if (step)       cnt_o[g] <= stepped;
      end

      assign fire_o[g] = step & ~wr_en_i[g] & stepped[CNT_W];
   end

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
   import irq_router_pkg::*;
#(
   parameter int NUM_CPU     = 4,
   parameter int NUM_LINES   = 64,
   parameter int LEGACY_LINE = 55,
   parameter int CNT_W       = 24,
   parameter bit TICK_RISING = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] dev_lines_i,
   input  logic                 legacy_pic_i,
   input  logic                 tick_i,
   input  logic                 bus_valid_i,
   input  logic                 bus_write_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic [1:0]           bus_cpu_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   output logic                 bus_err_o,
   output logic [NUM_CPU-1:0]   hard_irq_o,
   output logic [NUM_CPU-1:0]   ipi_o,
   output logic [NUM_CPU-1:0]   timer_irq_o
);

   if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("NUM_CPU must be 1 to 4");
   end
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("NUM_LINES must be 1 to DATA_W");
   end
   if (LEGACY_LINE < 0 || LEGACY_LINE >= NUM_LINES) begin : g_bad_legacy
      $error("LEGACY_LINE outside request vector");
   end
   if (CNT_W < 1 || CNT_W + 1 > DATA_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   logic [NUM_LINES-1:0]              req;
   logic [NUM_CPU-1:0][NUM_LINES-1:0] mask;
   logic [NUM_CPU-1:0][CNT_W:0]       cnt;
   logic [NUM_CPU-1:0]                fire;
   logic [NUM_CPU-1:0]                wr_mask;
   logic [NUM_CPU-1:0]                wr_cnt;
   logic [DATA_W-1:0]                 ctrl;
   logic                              wr_ctrl;
   logic                              bus_wr;

   assign bus_wr  = bus_valid_i & bus_write_i;
   assign wr_ctrl = bus_wr & (bus_addr_i == OFF_CTRL);

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_dec
      assign wr_mask[g] = bus_wr & (bus_addr_i == mask_off(g));
      assign wr_cnt[g]  = bus_wr & (bus_addr_i == cnt_off(g));
   end

   irq_req_capture #(.NUM_LINES(NUM_LINES), .LEGACY_LINE(LEGACY_LINE)) u_req (
      .clk(clk), .rst_n(rst_n), .lines_i(dev_lines_i),
      .legacy_i(legacy_pic_i), .req_o(req));

   irq_mask_bank #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_mask),
      .wdata_i(bus_wdata_i[NUM_LINES-1:0]), .req_i(req),
      .mask_o(mask), .hard_irq_o(hard_irq_o));

   irq_interval_bank #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .TICK_RISING(TICK_RISING)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_cnt),
      .wdata_i(bus_wdata_i[CNT_W-1:0]), .cnt_o(cnt), .fire_o(fire));

   irq_ctrl_word #(.NUM_CPU(NUM_CPU)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl), .wdata_i(bus_wdata_i),
      .fire_i(fire), .ctrl_o(ctrl), .ipi_o(ipi_o), .timer_irq_o(timer_irq_o));

   logic [DATA_W-1:0] rd;
   logic              hit;

   always_comb begin
      rd  = '0;
      hit = 1'b0;
      if (bus_addr_i == OFF_CTRL) begin
         rd  = ctrl | DATA_W'(bus_cpu_i);
         hit = 1'b1;
      end
      if (bus_addr_i == OFF_RAW) begin
         rd  = DATA_W'(req);
         hit = 1'b1;
      end
      for (int i = 0; i < NUM_CPU; i++) begin
         if (bus_addr_i == mask_off(i)) begin
            rd  = DATA_W'(mask[i]);
            hit = 1'b1;
         end
         if (bus_addr_i == view_off(i)) begin
            rd  = DATA_W'(mask[i] & req);
            hit = 1'b1;
         end
         if (bus_addr_i == cnt_off(i)) begin
            rd  = DATA_W'(cnt[i]);
            hit = 1'b1;
         end
      end
      if (!bus_valid_i)  bus_rdata_o = '0;
      else if (hit)      bus_rdata_o = rd;
      else               bus_rdata_o = '1;
      bus_err_o = bus_valid_i & ~hit;
   end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_router_pkg::*;
#(
   parameter int NUM_CPU   = 4,
   parameter int NUM_LINES = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] dev_lines_i,
   input logic                 legacy_pic_i,
   input logic                 tick_i,
   input logic                 bus_valid_i,
   input logic                 bus_write_i,
   input logic [ADDR_W-1:0]    bus_addr_i,
   input logic [DATA_W-1:0]    bus_wdata_i,
   input logic [DATA_W-1:0]    bus_rdata_o,
   input logic                 bus_err_o,
   input logic [NUM_CPU-1:0]   hard_irq_o,
   input logic [NUM_CPU-1:0]   timer_irq_o,
   input logic [NUM_CPU-1:0]   ipi_o
);

   logic ctrl_wr;
   assign ctrl_wr = bus_valid_i && bus_write_i && (bus_addr_i == OFF_CTRL);

   // R5: an error response always carries all-ones data
   a_r5_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err_o |-> (bus_rdata_o == '1));

   // R1: no active request source leaves every hard interrupt low a cycle later
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_lines_i == '0 && !legacy_pic_i) |=> (hard_irq_o == '0));

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
      // R3: an all-zero mask silences that processor
      a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_valid_i && bus_write_i && bus_addr_i == mask_off(g) && bus_wdata_i == '0)
         |=> !hard_irq_o[g]);

      // R9: the set field raises the inter-processor interrupt
      a_r9_ipi_raise: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_wr && bus_wdata_i[IPI_SET_LSB + g]) |=> ipi_o[g]);

      // R13: acknowledging with no tick edge drops the timer interrupt
      a_r13_timer_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_wr && bus_wdata_i[TACK_LSB + g] && !tick_i) |=> !timer_irq_o[g]);

      // R13: without a control write the timer interrupt holds
      a_r13_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (timer_irq_o[g] && !ctrl_wr) |=> timer_irq_o[g]);
   end

endmodule

bind irq_router_top irq_router_chk #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .dev_lines_i(dev_lines_i), .legacy_pic_i(legacy_pic_i),
   .tick_i(tick_i), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
   .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
   .bus_err_o(bus_err_o), .hard_irq_o(hard_irq_o), .timer_irq_o(timer_irq_o),
   .ipi_o(ipi_o));

// File: tb/irq_router_top_test.sv
module irq_router_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] dev_lines = '0;
   logic        legacy = 1'b0;
   logic        tick = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_cpu = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        bus_err;
   logic [3:0]  hard_irq, ipi, timer_irq;

   always #2.5 clk = ~clk;

   irq_router_top uut (
      .clk(clk), .rst_n(rst_n), .dev_lines_i(dev_lines), .legacy_pic_i(legacy),
      .tick_i(tick), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
      .bus_addr_i(bus_addr), .bus_cpu_i(bus_cpu), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .bus_err_o(bus_err), .hard_irq_o(hard_irq),
      .ipi_o(ipi), .timer_irq_o(timer_irq));

   typedef struct {
      int          kind;   // 0 read, 1 hard, 2 ipi, 3 timer
      int          idx;
      logic [63:0] exp;
      logic        exp_err;
   } item_t;

   item_t q[$];
   string tags[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // monitor: pops and compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            string tg;
            logic [63:0] act;
            logic        act_err;
            it = q.pop_front();
            tg = tags.pop_front();
            act_err = 1'b0;
            case (it.kind)
               0: begin act = bus_rdata; act_err = bus_err; end
               1: act = 64'(hard_irq[it.idx]);
               2: act = 64'(ipi[it.idx]);
               default: act = 64'(timer_irq[it.idx]);
            endcase
            checks++;
            if (act !== it.exp || act_err !== it.exp_err) begin
               fails++;
               $display("FAIL %s: actual=%h err=%b expected=%h err=%b",
                        tg, act, act_err, it.exp, it.exp_err);
            end
         end
      end
   end

   task automatic push(input int k, input int i, input logic [63:0] e,
                       input logic ee, input string tg);
      item_t it;
      it.kind = k; it.idx = i; it.exp = e; it.exp_err = ee;
      q.push_back(it);
      tags.push_back(tg);
   endtask

   task automatic rd(input logic [11:0] a, input logic [1:0] c,
                     input logic [63:0] e, input logic ee, input string tg);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_cpu = c;
      push(0, 0, e, ee, tg);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic pin(input int k, input int i, input logic e, input string tg);
      @(negedge clk);
      push(k, i, 64'(e), 1'b0, tg);
   endtask

   task automatic tick_pulse();
      @(negedge clk);
      tick = 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b0;
   endtask

   localparam logic [63:0] B3  = 64'h1 << 3;
   localparam logic [63:0] B55 = 64'h1 << 55;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      rd(12'h080, 2'd2, 64'h8_0000_0002, 1'b0, "R6 reset value with cpu id");
      pin(1, 0, 1'b0, "R3 reset hard irq");
      rd(12'h300, 2'd0, 64'h0, 1'b0, "R1 idle request");

      @(negedge clk); dev_lines = B3 | B55;
      rd(12'h300, 2'd0, B3, 1'b0, "R1 device line 55 hidden");
      @(negedge clk); legacy = 1'b1;
      rd(12'h300, 2'd0, B3 | B55, 1'b0, "R1 legacy drives bit 55");

      wr(12'h200, B3);
      pin(1, 0, 1'b1, "R3 mask0 hit");
      pin(1, 1, 1'b0, "R3 mask1 empty");
      rd(12'h280, 2'd0, B3, 1'b0, "R4 masked view 0");
      wr(12'h280, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(12'h300, 64'h0);
      rd(12'h300, 2'd0, B3 | B55, 1'b0, "R4 raw ignores writes");
      rd(12'h280, 2'd0, B3, 1'b0, "R4 view ignores writes");
      wr(12'h640, B55);
      rd(12'h640, 2'd0, B55, 1'b0, "R2 mask3 readback");
      pin(1, 3, 1'b1, "R3 mask3 legacy hit");
      rd(12'h6C0, 2'd0, B55, 1'b0, "R4 masked view 3");
      @(negedge clk); legacy = 1'b0;
      pin(1, 3, 1'b0, "R3 legacy drop");
      rd(12'h240, 2'd0, 64'h0, 1'b0, "R2 mask1 reset zero");

      rd(12'h008, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R5 undecoded low");
      rd(12'hFF8, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R5 undecoded high");

      wr(12'h080, 64'h3000);
      pin(2, 0, 1'b1, "R9 ipi0 set");
      pin(2, 1, 1'b1, "R9 ipi1 set");
      pin(2, 2, 1'b0, "R9 ipi2 clear");
      rd(12'h080, 2'd0, 64'h8_0000_0300, 1'b0, "R7 shifted set");
      wr(12'h080, 64'h100);
      rd(12'h080, 2'd0, 64'h8_0000_0200, 1'b0, "R7 write one clear");
      pin(2, 0, 1'b0, "R9 ipi0 cleared");
      wr(12'h080, 64'hA00_0000_0000);
      rd(12'h080, 2'd3, 64'hA08_0000_0203, 1'b0, "R7 spare field load, R6 id");
      wr(12'h080, 64'h500_0000_0000);
      rd(12'h080, 2'd0, 64'h508_0000_0200, 1'b0, "R7 spare field replace");

      wr(12'h080, 64'h43_0000);
      rd(12'h080, 2'd0, 64'h8_0043_0200, 1'b0, "R8 load when empty");
      wr(12'h080, 64'hAC_0000);
      rd(12'h080, 2'd0, 64'h8_00E3_0200, 1'b0, "R8 hold when full");
      wr(12'h080, 64'h10_0000);
      rd(12'h080, 2'd0, 64'h8_0000_0200, 1'b0, "R8 clear");
      wr(12'h080, 64'h0C_0000);
      rd(12'h080, 2'd0, 64'h8_000C_0200, 1'b0, "R8 reload");
      wr(12'h080, 64'h10_0200);
      rd(12'h080, 2'd0, 64'h8_0000_0000, 1'b0, "R8 R7 clear both");
      pin(2, 1, 1'b0, "R9 ipi1 cleared");

      wr(12'h380, 64'd2);
      wr(12'h3C0, 64'd100);
      wr(12'h700, 64'h100_0005);
      wr(12'h740, 64'd100);
      rd(12'h700, 2'd0, 64'd5, 1'b0, "R10 load drops bit 24");
      rd(12'h380, 2'd0, 64'd2, 1'b0, "R10 load");

      tick_pulse();
      rd(12'h380, 2'd0, 64'd1, 1'b0, "R11 one step per edge");
      rd(12'h700, 2'd0, 64'd4, 1'b0, "R11 counter 2 step");
      pin(3, 0, 1'b0, "R12 no timer yet");
      tick_pulse();
      pin(3, 0, 1'b0, "R12 zero is not underflow");
      rd(12'h080, 2'd0, 64'h8_0000_0000, 1'b0, "R12 no ack bit at zero");
      tick_pulse();
      rd(12'h380, 2'd0, 64'h1FF_FFFF, 1'b0, "R11 wrap sets bit 24");
      pin(3, 0, 1'b1, "R12 timer raised");
      rd(12'h080, 2'd1, 64'h8_0000_0011, 1'b0, "R12 ack bit set");
      pin(3, 1, 1'b0, "R12 other timer quiet");
      tick_pulse();
      rd(12'h380, 2'd0, 64'h1FF_FFFE, 1'b0, "R11 sticky decrement");

      wr(12'h080, 64'h10);
      pin(3, 0, 1'b0, "R13 ack drops timer");
      rd(12'h080, 2'd0, 64'h8_0000_0000, 1'b0, "R13 ack bit cleared");
      tick_pulse();
      pin(3, 0, 1'b1, "R12 sticky refire");
      wr(12'h080, 64'h1000);
      pin(3, 0, 1'b1, "R13 timer holds");
      rd(12'h080, 2'd0, 64'h8_0000_0110, 1'b0, "R13 ack bit kept");
      wr(12'h380, 64'd50);
      rd(12'h380, 2'd0, 64'd50, 1'b0, "R10 reload clears sticky");
      wr(12'h080, 64'h110);
      pin(3, 0, 1'b0, "R13 final ack");
      pin(2, 0, 1'b0, "R9 final ipi clear");
      rd(12'h3C0, 2'd0, 64'd95, 1'b0, "R11 counter 1 after five edges");
      pin(3, 2, 1'b0, "R12 counter 2 reached zero only");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule